// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the per-channel register interface of a descriptor-driven DMA engine. A host reaches it with 32-bit word reads and writes. Each channel owns a 128-byte window, and the channel number comes from the address bits above that window. The block stores the channel status word, the descriptor pointer and three condition-select words. A write to the control word changes the status word through a masked update, and a fixed set of derived-bit rules then corrects the result.

Several signals go to the sequencer that walks the descriptors:

- the live status word, whose bits carry the run, active, dead, flush and wake state;
- the pointer and the three select words;
- one-cycle request pulses: schedule the channel, flush the attached device, and fetch a descriptor after a pointer write.

The sequencer has three strobes: one sets the dead bit, one clears the active bit and one clears the branch-taken bit. Each strobe wins over a host write in the same cycle.

Register map (word index = address bits 6:2):

| Index | Register |
|---|---|
| 0 | control |
| 1 | status |
| 3 | pointer |
| 4 | interrupt select |
| 5 | branch select |
| 6 | wait select |

All other indices are reserved. A write to a reserved index does nothing, and a read of one returns zero.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the status word, pointer, all three select words and all request pulses are zero.
- R2: A control write uses data bits 31:16 as a mask and bits 15:0 as a value. Only the value bits RUN(15), PAUSE(14), FLUSH(13), WAKE(12) and device status (7:0) can be set. The merged status is (value & mask) | (old & ~mask), so the control write can never set DEAD(11), ACTIVE(10) or branch-taken(8).
- R3: After the merge, four rules apply in this order:
  - WAKE set forces ACTIVE.
  - RUN set forces ACTIVE and clears DEAD.
  - PAUSE set clears ACTIVE.
  - A RUN change from 1 to 0 clears both ACTIVE and DEAD.
- R4: A read of the control word returns zero. Reads of the status word, pointer and select words return the stored values.
- R5: A pointer write is ignored while RUN or ACTIVE is set. An accepted write stores the data with bits 3:0 cleared and gives a one-cycle fetch pulse.
- R6: In the cycle after a control write, run_req_o pulses if the new status has ACTIVE set, and flush_req_o pulses if it has FLUSH set.
- R7: The following have no effect on any state and read as zero:
  - accesses whose address bits above bit 6 differ from the channel number;
  - accesses with address bits 1:0 not zero;
  - accesses to reserved indices.
- R8: The sequencer strobes set DEAD, clear ACTIVE or clear branch-taken one cycle later. Each strobe wins over a host write in the same cycle. A control write whose ACTIVE is then cleared gives no run pulse.
- R9: A write to the status word stores data bits 15:0 as they are and raises no request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address |
| seq_set_dead_i | input | 1 | Sequencer: set DEAD |
| seq_clr_active_i | input | 1 | Sequencer: clear ACTIVE |
| seq_clr_bt_i | input | 1 | Sequencer: clear branch-taken |
| status_o | output | 16 | Status word |
| cmd_ptr_o | output | 32 | Descriptor pointer |
| int_sel_o | output | SEL_W | Interrupt condition select |
| br_sel_o | output | SEL_W | Branch condition select |
| wait_sel_o | output | SEL_W | Wait condition select |
| run_req_o | output | 1 | Schedule pulse |
| flush_req_o | output | 1 | Device flush pulse |
| fetch_req_o | output | 1 | Descriptor fetch pulse |

## Verification
Control writes are tried with several kinds of mask:
- Device-status-only masks show that the merge works apart from the derived bits.
- Masks aimed at DEAD and ACTIVE show that those bits cannot be written directly.
- Single-bit masks for RUN, PAUSE, WAKE and FLUSH separate the four priority rules, including the 1-to-0 RUN edge after DEAD was set.

Pointer writes are made both while the channel is running and while it is idle, which tells the lock apart from the alignment step. Control writes paired with sequencer strobes in the same cycle show which side wins. Writes to another channel, to a misaligned address and to a reserved index show that these leave all state unchanged.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int ST_W    = 16;
    localparam int WORD_W  = 2 * ST_W;

    // status bit positions (decoded by the sequencer)
    localparam int B_RUN   = 15;
    localparam int B_PAUSE = 14;
    localparam int B_FLUSH = 13;
    localparam int B_WAKE  = 12;
    localparam int B_DEAD  = 11;
    localparam int B_ACT   = 10;
    localparam int B_BT    = 8;

    // value bits a control write is allowed to drive
    localparam logic [ST_W-1:0] CTRL_HONOR = 16'hF0FF;

    // word indices inside the channel window
    localparam int IX_CTRL = 0;
    localparam int IX_STAT = 1;
    localparam int IX_PTR  = 3;
    localparam int IX_ISEL = 4;
    localparam int IX_BSEL = 5;
    localparam int IX_WSEL = 6;

    typedef struct packed {
        logic ctrl;
        logic stat;
        logic ptr;
        logic isel;
        logic bsel;
        logic wsel;
    } reg_sel_t;

endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int CHAN_SHIFT = 7,
    parameter int CHAN_ID    = 2
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    localparam int CHAN_W = ADDR_W - CHAN_SHIFT;
    localparam int IX_W   = CHAN_SHIFT - 2;
    localparam logic [CHAN_W-1:0] CHAN_BITS = CHAN_W'(CHAN_ID);

    logic            hit;
    logic [IX_W-1:0] ix;

    always_comb begin
        hit = en_i && (addr_i[ADDR_W-1:CHAN_SHIFT] == CHAN_BITS)
                   && (addr_i[1:0] == 2'b00);
        ix  = addr_i[CHAN_SHIFT-1:2];
        sel_o.ctrl = hit && (ix == IX_W'(IX_CTRL));
        sel_o.stat = hit && (ix == IX_W'(IX_STAT));
        sel_o.ptr  = hit && (ix == IX_W'(IX_PTR));
        sel_o.isel = hit && (ix == IX_W'(IX_ISEL));
        sel_o.bsel = hit && (ix == IX_W'(IX_BSEL));
        sel_o.wsel = hit && (ix == IX_W'(IX_WSEL));
    end
endmodule

// File: rtl/dma_chan_ctrl_merge.sv
module dma_chan_ctrl_merge
    import dma_chan_pkg::*;
(
    input  logic [ST_W-1:0]   old_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [ST_W-1:0]   new_o
);
    logic [ST_W-1:0] mask;
    logic [ST_W-1:0] val;
    logic [ST_W-1:0] s;

    always_comb begin
        mask = wdata_i[WORD_W-1:ST_W];
        val  = wdata_i[ST_W-1:0] & CTRL_HONOR;
        s    = (val & mask) | (old_i & ~mask);
        // derived bits, order matters: later rules win
        if (s[B_WAKE]) s[B_ACT] = 1'b1;
        if (s[B_RUN]) begin
            s[B_ACT]  = 1'b1;
            s[B_DEAD] = 1'b0;
        end
        if (s[B_PAUSE]) s[B_ACT] = 1'b0;
        if (old_i[B_RUN] && !s[B_RUN]) begin
            s[B_ACT]  = 1'b0;
            s[B_DEAD] = 1'b0;
        end
        new_o = s;
    end
endmodule

// File: rtl/dma_chan_rdmux.sv
module dma_chan_rdmux
    import dma_chan_pkg::*;
#(
    parameter int SEL_W = 32
) (
    input  reg_sel_t          sel_i,
    input  logic [ST_W-1:0]   status_i,
    input  logic [WORD_W-1:0] ptr_i,
    input  logic [SEL_W-1:0]  isel_i,
    input  logic [SEL_W-1:0]  bsel_i,
    input  logic [SEL_W-1:0]  wsel_i,
    output logic [WORD_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (sel_i.ctrl)      rdata_o = '0;   // control is write-only
        else if (sel_i.stat) rdata_o = WORD_W'(status_i);
        else if (sel_i.ptr)  rdata_o = ptr_i;
        else if (sel_i.isel) rdata_o = WORD_W'(isel_i);
        else if (sel_i.bsel) rdata_o = WORD_W'(bsel_i);
        else if (sel_i.wsel) rdata_o = WORD_W'(wsel_i);
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int CHAN_SHIFT = 7,
    parameter int CHAN_ID    = 2,
    parameter int SEL_W      = 32,
    parameter int PTR_ALIGN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              seq_set_dead_i,
    input  logic              seq_clr_active_i,
    input  logic              seq_clr_bt_i,
    output logic [15:0]       status_o,
    output logic [31:0]       cmd_ptr_o,
    output logic [SEL_W-1:0]  int_sel_o,
    output logic [SEL_W-1:0]  br_sel_o,
    output logic [SEL_W-1:0]  wait_sel_o,
    output logic              run_req_o,
    output logic              flush_req_o,
    output logic              fetch_req_o
);
    localparam int PTR_KEEP = WORD_W - PTR_ALIGN;

    typedef struct packed {
        logic [ST_W-1:0]   status;
        logic [WORD_W-1:0] ptr;
        logic [SEL_W-1:0]  isel;
        logic [SEL_W-1:0]  bsel;
        logic [SEL_W-1:0]  wsel;
        logic              run_req;
        logic              flush_req;
        logic              fetch_req;
    } chan_state_t;

    chan_state_t     st_d, st_q;
    reg_sel_t        wsel_dec, rsel_dec;
    logic [ST_W-1:0] merged;
    logic [ST_W-1:0] st_next;
    logic            ptr_locked;

    dma_chan_decode #(.ADDR_W(ADDR_W), .CHAN_SHIFT(CHAN_SHIFT), .CHAN_ID(CHAN_ID))
        u_wr_dec (.en_i(wr_en_i), .addr_i(addr_i), .sel_o(wsel_dec));

    dma_chan_decode #(.ADDR_W(ADDR_W), .CHAN_SHIFT(CHAN_SHIFT), .CHAN_ID(CHAN_ID))
        u_rd_dec (.en_i(rd_en_i), .addr_i(addr_i), .sel_o(rsel_dec));

    dma_chan_ctrl_merge u_merge (.old_i(st_q.status), .wdata_i(wdata_i), .new_o(merged));

    dma_chan_rdmux #(.SEL_W(SEL_W)) u_rdmux (
        .sel_i   (rsel_dec),
        .status_i(st_q.status),
        .ptr_i   (st_q.ptr),
        .isel_i  (st_q.isel),
        .bsel_i  (st_q.bsel),
        .wsel_i  (st_q.wsel),
        .rdata_o (rdata_o)
    );

    always_comb begin
        st_d           = st_q;
        st_d.run_req   = 1'b0;
        st_d.flush_req = 1'b0;
        st_d.fetch_req = 1'b0;
        ptr_locked     = st_q.status[B_RUN] | st_q.status[B_ACT];

        st_next = st_q.status;
        if (wsel_dec.ctrl)      st_next = merged;
        else if (wsel_dec.stat) st_next = wdata_i[ST_W-1:0];

        // sequencer strobes override the host
        if (seq_set_dead_i)   st_next[B_DEAD] = 1'b1;
        if (seq_clr_active_i) st_next[B_ACT]  = 1'b0;
        if (seq_clr_bt_i)     st_next[B_BT]   = 1'b0;
        st_d.status = st_next;

        if (wsel_dec.ctrl) begin
            st_d.run_req   = st_next[B_ACT];
            st_d.flush_req = st_next[B_FLUSH];
        end

        if (wsel_dec.ptr && !ptr_locked) begin
            st_d.ptr       = {wdata_i[WORD_W-1:PTR_ALIGN], {PTR_ALIGN{1'b0}}};
            st_d.fetch_req = 1'b1;
        end
        if (wsel_dec.isel) st_d.isel = wdata_i[SEL_W-1:0];
        if (wsel_dec.bsel) st_d.bsel = wdata_i[SEL_W-1:0];
        if (wsel_dec.wsel) st_d.wsel = wdata_i[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o    = st_q.status;
    assign cmd_ptr_o   = st_q.ptr;
    assign int_sel_o   = st_q.isel;
    assign br_sel_o    = st_q.bsel;
    assign wait_sel_o  = st_q.wsel;
    assign run_req_o   = st_q.run_req;
    assign flush_req_o = st_q.flush_req;
    assign fetch_req_o = st_q.fetch_req;

    initial begin
        if (PTR_KEEP <= 0) $error("PTR_ALIGN too large");
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
    import dma_chan_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] status_o,
    input logic [31:0] cmd_ptr_o,
    input logic        run_req_o,
    input logic        flush_req_o,
    input logic        fetch_req_o,
    input logic        seq_set_dead_i,
    input logic        seq_clr_active_i
);
    // R5: a running or active channel keeps its pointer
    a_r5_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[B_RUN] || status_o[B_ACT]) |=> $stable(cmd_ptr_o));

    // R5: a fetch pulse only follows a write accepted while unlocked
    a_r5_fetch_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> !($past(status_o[B_RUN]) || $past(status_o[B_ACT])));

    // R6: the schedule pulse coincides with an active channel
    a_r6_run_req_active: assert property (@(posedge clk) disable iff (!rst_n)
        run_req_o |-> status_o[B_ACT]);

    // R6: the flush pulse coincides with FLUSH set
    a_r6_flush_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |-> status_o[B_FLUSH]);

    // R3: no schedule pulse while paused
    a_r3_pause_blocks_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_req_o |-> !status_o[B_PAUSE]);

    // R8: sequencer strobes win
    a_r8_dead_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seq_set_dead_i |=> status_o[B_DEAD]);

    a_r8_active_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr_active_i |=> !status_o[B_ACT]);
endmodule

bind dma_chan_regs dma_chan_regs_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .status_o        (status_o),
    .cmd_ptr_o       (cmd_ptr_o),
    .run_req_o       (run_req_o),
    .flush_req_o     (flush_req_o),
    .fetch_req_o     (fetch_req_o),
    .seq_set_dead_i  (seq_set_dead_i),
    .seq_clr_active_i(seq_clr_active_i)
);

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] BASE  = 12'h100;  // channel 2
    localparam logic [ADDR_W-1:0] A_CTL = BASE + 12'h00;
    localparam logic [ADDR_W-1:0] A_ST  = BASE + 12'h04;
    localparam logic [ADDR_W-1:0] A_PTR = BASE + 12'h0C;
    localparam logic [ADDR_W-1:0] A_IS  = BASE + 12'h10;
    localparam logic [ADDR_W-1:0] A_BS  = BASE + 12'h14;
    localparam logic [ADDR_W-1:0] A_WS  = BASE + 12'h18;
    localparam logic [ADDR_W-1:0] A_RSV = BASE + 12'h1C;

    // observation points
    localparam int O_RD = 0, O_ST = 1, O_PTR = 2, O_RUN = 3, O_FL = 4, O_FE = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              sd = 1'b0, ca = 1'b0, cb = 1'b0;
    logic [15:0]       status;
    logic [31:0]       cmd_ptr, isel, bsel, wsel;
    logic              run_req, flush_req, fetch_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          obs;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     mon_ev;

    always #2.5 clk = ~clk;

    dma_chan_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .seq_set_dead_i(sd), .seq_clr_active_i(ca), .seq_clr_bt_i(cb),
        .status_o(status), .cmd_ptr_o(cmd_ptr), .int_sel_o(isel),
        .br_sel_o(bsel), .wait_sel_o(wsel), .run_req_o(run_req),
        .flush_req_o(flush_req), .fetch_req_o(fetch_req)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.obs)
                    O_RD:    act = rdata;
                    O_ST:    act = {16'h0, status};
                    O_PTR:   act = cmd_ptr;
                    O_RUN:   act = {31'h0, run_req};
                    O_FL:    act = {31'h0, flush_req};
                    default: act = {31'h0, fetch_req};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s obs=%0d actual=%h expected=%h", it.tag, it.obs, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(int obs, logic [31:0] exp, string tag);
        sb_item_t it;
        it.obs = obs; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic fire();
        -> mon_ev;
        #0.1;
    endtask

    // drive one cycle of host write plus sequencer strobes; returns at the next negedge
    task automatic cyc(logic we, logic [ADDR_W-1:0] a, logic [31:0] d,
                       logic s_dead, logic c_act, logic c_bt);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; sd = s_dead; ca = c_act; cb = c_bt;
        @(negedge clk);
        wr_en = 1'b0; sd = 1'b0; ca = 1'b0; cb = 1'b0;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd_chk(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        expect_v(O_RD, exp, tag);
        fire();
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulses(logic r, logic f, logic fe, string tag);
        expect_v(O_RUN, {31'h0, r},  tag);
        expect_v(O_FL,  {31'h0, f},  tag);
        expect_v(O_FE,  {31'h0, fe}, tag);
    endtask

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_v(O_ST, 32'h0, "R1 status");
        expect_v(O_PTR, 32'h0, "R1 ptr");
        pulses(1'b0, 1'b0, 1'b0, "R1 pulses");
        fire();
        rd_chk(A_IS, 32'h0, "R1 isel");

        // R5: accepted pointer write aligned, fetch pulse
        wr(A_PTR, 32'h1234_5678);
        expect_v(O_PTR, 32'h1234_5670, "R5 ptr aligned");
        pulses(1'b0, 1'b0, 1'b1, "R5 fetch pulse");
        fire();
        rd_chk(A_PTR, 32'h1234_5670, "R4 ptr readback");

        // R4: select words read back
        wr(A_IS, 32'hA5A5_0F0F);
        wr(A_BS, 32'h0003_0001);
        wr(A_WS, 32'hFFFF_0002);
        rd_chk(A_IS, 32'hA5A5_0F0F, "R4 isel");
        rd_chk(A_BS, 32'h0003_0001, "R4 bsel");
        rd_chk(A_WS, 32'hFFFF_0002, "R4 wsel");

        // R2: device status through mask
        wr(A_CTL, 32'h00FF_005A);
        expect_v(O_ST, 32'h005A, "R2 devstat");
        pulses(1'b0, 1'b0, 1'b0, "R2 no pulses");
        fire();
        // R2: DEAD/ACTIVE not writable
        wr(A_CTL, 32'h0D00_0D00);
        expect_v(O_ST, 32'h005A, "R2 dead/active/bt locked");
        fire();
        rd_chk(A_CTL, 32'h0, "R4 control reads zero");

        // R3/R6: RUN forces ACTIVE
        wr(A_CTL, 32'h8000_8000);
        expect_v(O_ST, 32'h845A, "R3 run->active");
        pulses(1'b1, 1'b0, 1'b0, "R6 run pulse");
        fire();

        // R5: pointer locked while running
        wr(A_PTR, 32'hDEAD_BEEF);
        expect_v(O_PTR, 32'h1234_5670, "R5 ptr locked");
        pulses(1'b0, 1'b0, 1'b0, "R5 no fetch");
        fire();

        // R8: sequencer sets DEAD
        cyc(1'b0, A_CTL, 32'h0, 1'b1, 1'b0, 1'b0);
        expect_v(O_ST, 32'h8C5A, "R8 set dead");
        fire();
        // R3: RUN set clears DEAD
        wr(A_CTL, 32'h8000_8000);
        expect_v(O_ST, 32'h845A, "R3 run clears dead");
        fire();

        // R3: PAUSE beats RUN
        wr(A_CTL, 32'h4000_4000);
        expect_v(O_ST, 32'hC05A, "R3 pause clears active");
        pulses(1'b0, 1'b0, 1'b0, "R6 no run pulse paused");
        fire();
        wr(A_CTL, 32'h4000_0000);
        expect_v(O_ST, 32'h845A, "R3 unpause");
        expect_v(O_RUN, 32'h1, "R6 run pulse after unpause");
        fire();

        // R3: RUN 1->0 clears ACTIVE and DEAD
        cyc(1'b0, A_CTL, 32'h0, 1'b1, 1'b0, 1'b0);
        expect_v(O_ST, 32'h8C5A, "R8 set dead again");
        fire();
        wr(A_CTL, 32'h8000_0000);
        expect_v(O_ST, 32'h005A, "R3 run fall");
        pulses(1'b0, 1'b0, 1'b0, "R6 idle after stop");
        fire();

        // R3: WAKE forces ACTIVE
        wr(A_CTL, 32'h1000_1000);
        expect_v(O_ST, 32'h145A, "R3 wake->active");
        expect_v(O_RUN, 32'h1, "R6 wake pulse");
        fire();

        // R6: FLUSH request
        wr(A_CTL, 32'h2000_2000);
        expect_v(O_ST, 32'h345A, "R6 flush set");
        pulses(1'b1, 1'b1, 1'b0, "R6 flush pulse");
        fire();

        // R8: strobes beat a same-cycle RUN write
        cyc(1'b1, A_CTL, 32'h8000_8000, 1'b1, 1'b1, 1'b0);
        expect_v(O_ST, 32'hB85A, "R8 strobes win");
        pulses(1'b0, 1'b1, 1'b0, "R8 no run pulse");
        fire();

        // R9: direct status write, then R8 clear branch-taken
        wr(A_ST, 32'hFFFF_0100);
        expect_v(O_ST, 32'h0100, "R9 status stored");
        pulses(1'b0, 1'b0, 1'b0, "R9 no pulses");
        fire();
        cyc(1'b0, A_CTL, 32'h0, 1'b0, 1'b0, 1'b1);
        expect_v(O_ST, 32'h0000, "R8 clear bt");
        fire();

        // R7: other channel, misaligned, reserved
        wr(12'h18C, 32'hFFFF_FFF0);
        expect_v(O_PTR, 32'h1234_5670, "R7 other channel ptr");
        pulses(1'b0, 1'b0, 1'b0, "R7 no fetch");
        fire();
        wr(A_IS + 12'h2, 32'h0);
        rd_chk(A_IS, 32'hA5A5_0F0F, "R7 misaligned ignored");
        wr(A_RSV, 32'hFFFF_FFFF);
        expect_v(O_ST, 32'h0000, "R7 reserved write");
        fire();
        rd_chk(A_RSV, 32'h0, "R7 reserved reads zero");
        rd_chk(12'h184, 32'h0, "R7 other channel read");
        wr(12'h080, 32'hFFFF_FFFF);
        expect_v(O_ST, 32'h0000, "R7 other channel control");
        fire();

        // R5: unlocked again, new pointer accepted
        wr(A_PTR, 32'hDEAD_BEEF);
        expect_v(O_PTR, 32'hDEAD_BEE0, "R5 ptr accepted");
        expect_v(O_FE, 32'h1, "R5 fetch pulse 2");
        fire();

        #1;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule